// File: doc/BRIEF.md
# Bit-Manipulation ALU

This is a purely combinational 64-bit execution unit for a scalar core. It carries out a family of bit-manipulation operations picked by a 4-bit opcode: add with a scaled second operand, signed and unsigned field extraction between two bit positions, leading-zero counts of the operand or its complement, byte reversal of the full value or of the low word, a per-byte zero test, a single-bit test, and right rotation over 64 or 32 bits.

The core's decode stage supplies the opcode, two operands, a 6-bit amount and the two field positions. The unit returns a 64-bit result and a write enable. The write enable lets an empty field extraction, or an opcode with no meaning, leave the destination register untouched. Register-file access and instruction decoding belong to the surrounding pipeline.

The block has no states and no registers. Each result depends only on the inputs present in the same cycle.

Top module: `bm_alu`

## Requirements
- R1: Opcodes 0, 1 and 2 return op_a + (op_b << k) modulo 2^64, with k = 1, 2 and 3 respectively; only op_b is shifted.
- R2: Opcode 3 (signed) and opcode 4 (unsigned) place bits [fld_msb:fld_lsb] of op_a in the low bits of the result. Width is fld_msb - fld_lsb + 1. The upper bits are copies of op_a[fld_msb] for opcode 3 and zero for opcode 4.
- R3: For opcodes 3 and 4 with fld_lsb > fld_msb, wr_en is 0 and result is 0.
- R4: Opcode 5 returns the number of leading zeros of ~op_a, and opcode 6 returns the number of leading zeros of op_a. An all-zero input to the count gives 64.
- R5: Opcode 7 reverses the order of all eight bytes of op_a. Opcode 8 reverses the four low bytes and fills bits 63:32 with bit 31 of that reversed word.
- R6: Opcode 9 sets each result byte to 0xFF where the matching byte of op_a is zero, and to 0x00 otherwise.
- R7: Opcode 10 returns op_a[amount] in bit 0, with every other bit zero.
- R8: Opcode 11 rotates op_a right by amount over 64 bits. Opcode 12 rotates op_a[31:0] right by amount[4:0] and sign-extends the 32-bit outcome.
- R9: Every opcode from 0 to 12 asserts wr_en, except the empty extraction of R3. Opcodes 13 to 15 give wr_en = 0 and result = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (scaled add only) |
| opcode | input | 4 | Operation select |
| amount | input | 6 | Rotate amount or bit index |
| fld_msb | input | 6 | Upper bit position of the extracted field |
| fld_lsb | input | 6 | Lower bit position of the extracted field |
| result | output | 64 | Operation result |
| wr_en | output | 1 | Destination write enable |

## Verification
Some properties are checked whenever the inputs change:
- the suppression rule for an empty field;
- the write enable for defined and undefined opcodes;
- the single-bit shape of the bit test;
- the 0x00/0xFF byte pattern of the zero test;
- the sign fill above the reversed word;
- the upper bound of the leading-zero counts.

The bench scenarios are needed for the arithmetic values themselves, which no per-cycle shape check can pin down:
- scaled sums that wrap;
- exact field contents and sign extension at full width and single-bit width;
- counts for all-zero and all-one operands;
- rotation by 0, by 63 and by a word amount that has bit 5 set.

// File: rtl/bm_alu_pkg.sv
package bm_alu_pkg;

    typedef enum logic [3:0] {
        OP_SADD1   = 4'd0,
        OP_SADD2   = 4'd1,
        OP_SADD3   = 4'd2,
        OP_FEXT_S  = 4'd3,
        OP_FEXT_U  = 4'd4,
        OP_LZ_INV  = 4'd5,
        OP_LZ      = 4'd6,
        OP_BSWAP   = 4'd7,
        OP_BSWAP_W = 4'd8,
        OP_ZBYTE   = 4'd9,
        OP_BTEST   = 4'd10,
        OP_ROTR    = 4'd11,
        OP_ROTR_W  = 4'd12
    } alu_op_e;

endpackage

// File: rtl/bm_field_extract.sv
module bm_field_extract #(
    parameter int W = 64
) (
    input  logic [W-1:0]         src,
    input  logic [$clog2(W)-1:0] hi_pos,
    input  logic [$clog2(W)-1:0] lo_pos,
    input  logic                 sign_mode,
    output logic [W-1:0]         field,
    output logic                 valid
);
    localparam int IW = $clog2(W);

    logic [IW:0]  span;
    logic [W-1:0] shifted;
    logic [W-1:0] keep_mask;
    logic [W-1:0] top_bit;
    logic         fill;

    always_comb begin
        valid   = (lo_pos <= hi_pos);
        span    = {1'b0, hi_pos} - {1'b0, lo_pos} + {{IW{1'b0}}, 1'b1};
        shifted = src >> lo_pos;
        if (span >= (IW+1)'(W)) begin
            keep_mask = {W{1'b1}};
        end else begin
            keep_mask = ~({W{1'b1}} << span);
        end
        // Highest bit kept in the field; used to pick up its sign.
        top_bit = keep_mask & ~(keep_mask >> 1);
        fill    = sign_mode & (|(shifted & top_bit));
        if (valid) begin
            field = (shifted & keep_mask) | (fill ? ~keep_mask : {W{1'b0}});
        end else begin
            field = {W{1'b0}};
        end
    end
endmodule

// File: rtl/bm_lead_zero.sv
module bm_lead_zero #(
    parameter int W = 64
) (
    input  logic [W-1:0]           src,
    output logic [$clog2(W):0]     count
);
    localparam int CW = $clog2(W) + 1;

    always_comb begin
        count = CW'(W);
        // The highest set bit is visited last, so its count is the one kept.
        for (int i = 0; i < W; i++) begin
            if (src[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/bm_byte_ops.sv
module bm_byte_ops #(
    parameter int W = 64
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] swap_full,
    output logic [W-1:0] swap_word,
    output logic [W-1:0] zero_map
);
    localparam int NB = W / 8;
    localparam int HB = NB / 2;
    localparam int HW = W / 2;

    logic [HW-1:0] low_swapped;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_byte
            assign swap_full[8*g +: 8] = src[8*(NB-1-g) +: 8];
            assign zero_map[8*g +: 8]  = {8{~(|src[8*g +: 8])}};
        end
        for (g = 0; g < HB; g++) begin : g_half
            assign low_swapped[8*g +: 8] = src[8*(HB-1-g) +: 8];
        end
    endgenerate

    assign swap_word = {{HW{low_swapped[HW-1]}}, low_swapped};
endmodule

// File: rtl/bm_rotator.sv
module bm_rotator #(
    parameter int W = 64
) (
    input  logic [W-1:0]         src,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         rot_full,
    output logic [W-1:0]         rot_word
);
    localparam int HW  = W / 2;
    localparam int HAW = $clog2(HW);

    logic [2*W-1:0]  dbl_full;
    logic [2*HW-1:0] dbl_word;

    always_comb begin
        dbl_full = {src, src} >> amt;
        dbl_word = {src[HW-1:0], src[HW-1:0]} >> amt[HAW-1:0];
        rot_full = dbl_full[W-1:0];
        rot_word = {{HW{dbl_word[HW-1]}}, dbl_word[HW-1:0]};
    end
endmodule

// File: rtl/bm_alu.sv
module bm_alu
    import bm_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    input  logic [3:0]           opcode,
    input  logic [$clog2(W)-1:0] amount,
    input  logic [$clog2(W)-1:0] fld_msb,
    input  logic [$clog2(W)-1:0] fld_lsb,
    output logic [W-1:0]         result,
    output logic                 wr_en
);
    localparam int CW = $clog2(W) + 1;

    alu_op_e       op_sel;
    logic [W-1:0]  fext_val;
    logic          fext_ok;
    logic [CW-1:0] lz_inv_cnt;
    logic [CW-1:0] lz_cnt;
    logic [W-1:0]  bswap_full;
    logic [W-1:0]  bswap_word;
    logic [W-1:0]  zbyte_map;
    logic [W-1:0]  rot_full;
    logic [W-1:0]  rot_word;

    assign op_sel = alu_op_e'(opcode);

    bm_field_extract #(.W(W)) i_fext (
        .src      (op_a),
        .hi_pos   (fld_msb),
        .lo_pos   (fld_lsb),
        .sign_mode(opcode == OP_FEXT_S),
        .field    (fext_val),
        .valid    (fext_ok)
    );

    bm_lead_zero #(.W(W)) i_lz_inv (
        .src  (~op_a),
        .count(lz_inv_cnt)
    );

    bm_lead_zero #(.W(W)) i_lz (
        .src  (op_a),
        .count(lz_cnt)
    );

    bm_byte_ops #(.W(W)) i_bytes (
        .src      (op_a),
        .swap_full(bswap_full),
        .swap_word(bswap_word),
        .zero_map (zbyte_map)
    );

    bm_rotator #(.W(W)) i_rot (
        .src     (op_a),
        .amt     (amount),
        .rot_full(rot_full),
        .rot_word(rot_word)
    );

    always_comb begin
        result = {W{1'b0}};
        wr_en  = 1'b1;
        unique case (op_sel)
            OP_SADD1:   result = op_a + (op_b << 1);
            OP_SADD2:   result = op_a + (op_b << 2);
            OP_SADD3:   result = op_a + (op_b << 3);
            OP_FEXT_S,
            OP_FEXT_U: begin
                result = fext_val;
                wr_en  = fext_ok;
            end
            OP_LZ_INV:  result = {{(W-CW){1'b0}}, lz_inv_cnt};
            OP_LZ:      result = {{(W-CW){1'b0}}, lz_cnt};
            OP_BSWAP:   result = bswap_full;
            OP_BSWAP_W: result = bswap_word;
            OP_ZBYTE:   result = zbyte_map;
            OP_BTEST:   result = {{(W-1){1'b0}}, op_a[amount]};
            OP_ROTR:    result = rot_full;
            OP_ROTR_W:  result = rot_word;
            default: begin
                result = {W{1'b0}};
                wr_en  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bm_alu_checker.sv
module bm_alu_checker #(
    parameter int W = 64
) (
    input logic [W-1:0]         op_a,
    input logic [3:0]           opcode,
    input logic [$clog2(W)-1:0] amount,
    input logic [$clog2(W)-1:0] fld_msb,
    input logic [$clog2(W)-1:0] fld_lsb,
    input logic [W-1:0]         result,
    input logic                 wr_en
);
    always_comb begin
        if (opcode == 4'd3 || opcode == 4'd4) begin
            assert_empty_field_R3: assert ((fld_lsb <= fld_msb) == wr_en)
                else $error("empty-field gating wrong");
        end
        if (opcode >= 4'd13) begin
            assert_undef_quiet_R9: assert (!wr_en && result == '0)
                else $error("undefined opcode wrote");
        end else if (opcode != 4'd3 && opcode != 4'd4) begin
            assert_defined_writes_R9: assert (wr_en)
                else $error("defined opcode lacks write enable");
        end
        if (opcode == 4'd10) begin
            assert_bit_test_R7: assert (result[W-1:1] == '0 && result[0] == op_a[amount])
                else $error("bit test shape wrong");
        end
        if (opcode == 4'd9) begin
            for (int b = 0; b < W/8; b++) begin
                assert_zero_byte_R6: assert (result[8*b +: 8] == 8'h00 || result[8*b +: 8] == 8'hFF)
                    else $error("zero-test byte not uniform");
            end
        end
        if (opcode == 4'd8) begin
            assert_word_sext_R5: assert (result[W-1:W/2] == {(W/2){result[W/2-1]}})
                else $error("word swap not sign extended");
        end
        if (opcode == 4'd5 || opcode == 4'd6) begin
            assert_count_bound_R4: assert (result <= W)
                else $error("leading-zero count out of range");
        end
    end
endmodule

bind bm_alu bm_alu_checker #(.W(W)) i_bm_alu_checker (
    .op_a   (op_a),
    .opcode (opcode),
    .amount (amount),
    .fld_msb(fld_msb),
    .fld_lsb(fld_lsb),
    .result (result),
    .wr_en  (wr_en)
);

// File: tb/test_bm_alu.sv
module test_bm_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [5:0]  amount = '0;
    logic [5:0]  fld_msb = '0;
    logic [5:0]  fld_lsb = '0;
    logic [63:0] result;
    logic        wr_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    logic [63:0] q_res[$];
    logic        q_we[$];
    string       q_tag[$];

    bm_alu i_bm_alu (
        .op_a(op_a), .op_b(op_b), .opcode(opcode), .amount(amount),
        .fld_msb(fld_msb), .fld_lsb(fld_lsb), .result(result), .wr_en(wr_en)
    );

    always #5 clk = ~clk;

    function automatic int lead0(logic [63:0] x);
        int n = 0;
        for (int i = 63; i >= 0; i--) begin
            if (x[i]) return n;
            n++;
        end
        return n;
    endfunction

    function automatic logic [64:0] model(int op, logic [63:0] a, logic [63:0] b,
                                          int amt, int msb, int lsb);
        logic [63:0] r = '0;
        logic        we = 1'b1;
        int          s;
        case (op)
            0, 1, 2: r = a + b * (64'd1 << (op + 1));
            3, 4: begin
                if (lsb > msb) begin
                    we = 1'b0;
                end else begin
                    for (int i = 0; i < 64; i++) begin
                        if (lsb + i <= msb) r[i] = a[lsb + i];
                        else r[i] = (op == 3) ? a[msb] : 1'b0;
                    end
                end
            end
            5: r = 64'(lead0(~a));
            6: r = 64'(lead0(a));
            7: for (int j = 0; j < 8; j++) r[8*j +: 8] = a[8*(7-j) +: 8];
            8: begin
                for (int j = 0; j < 4; j++) r[8*j +: 8] = a[8*(3-j) +: 8];
                for (int i = 32; i < 64; i++) r[i] = r[31];
            end
            9: for (int j = 0; j < 8; j++) r[8*j +: 8] = (a[8*j +: 8] == 8'h00) ? 8'hFF : 8'h00;
            10: r[0] = a[amt];
            11: for (int i = 0; i < 64; i++) r[i] = a[(i + amt) % 64];
            12: begin
                s = amt % 32;
                for (int i = 0; i < 32; i++) r[i] = a[(i + s) % 32];
                for (int i = 32; i < 64; i++) r[i] = r[31];
            end
            default: we = 1'b0;
        endcase
        return {we, r};
    endfunction

    task automatic drive(int op, logic [63:0] a, logic [63:0] b,
                         int amt, int msb, int lsb, string tag);
        logic [64:0] e;
        @(negedge clk);
        opcode  = 4'(op);
        op_a    = a;
        op_b    = b;
        amount  = 6'(amt);
        fld_msb = 6'(msb);
        fld_lsb = 6'(lsb);
        e = model(op, a, b, amt, msb, lsb);
        q_res.push_back(e[63:0]);
        q_we.push_back(e[64]);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares the settled combinational outputs half a cycle after drive.
    always @(posedge clk) begin
        if (rst_n && q_res.size() > 0) begin
            logic [63:0] er;
            logic        ew;
            string       t;
            er = q_res.pop_front();
            ew = q_we.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (result !== er || wr_en !== ew) begin
                errors++;
                $display("FAIL %s: got result=%h we=%b expected result=%h we=%b",
                         t, result, wr_en, er, ew);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 64'h0, 64'h0, 0, 0, 0, "reset-state R1");
        drive(0, 64'h10, 64'h3, 0, 0, 0, "R1 k1");
        drive(1, 64'h10, 64'h3, 0, 0, 0, "R1 k2");
        drive(2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h5, 0, 0, 0, "R1 k3 wrap");
        drive(2, 64'h3, 64'h0, 0, 0, 0, "R1 op_a not shifted");
        drive(3, 64'h0000_0000_0000_0F00, 0, 0, 11, 8, "R2 signed neg");
        drive(3, 64'h0000_0000_0000_0700, 0, 0, 11, 8, "R2 signed pos");
        drive(4, 64'h0000_0000_0000_0F00, 0, 0, 11, 8, "R2 unsigned");
        drive(3, 64'h8123_4567_89AB_CDEF, 0, 0, 63, 0, "R2 full width");
        drive(4, 64'h8000_0000_0000_0000, 0, 0, 63, 63, "R2 single top bit");
        drive(3, 64'h8000_0000_0000_0000, 0, 0, 63, 63, "R2 single top signed");
        drive(3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 4, 5, "R3 empty signed");
        drive(4, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 63, "R3 empty unsigned");
        drive(5, 64'hFFFF_0000_0000_0000, 0, 0, 0, 0, "R4 ff0");
        drive(5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "R4 ff0 all ones");
        drive(6, 64'h0000_0001_0000_0000, 0, 0, 0, 0, "R4 ff1");
        drive(6, 64'h0, 0, 0, 0, 0, "R4 ff1 zero");
        drive(6, 64'h8000_0000_0000_0000, 0, 0, 0, 0, "R4 ff1 top");
        drive(7, 64'h0102_0304_0506_0708, 0, 0, 0, 0, "R5 full swap");
        drive(8, 64'hAAAA_AAAA_1122_3344, 0, 0, 0, 0, "R5 word swap pos");
        drive(8, 64'h0000_0000_1122_33C4, 0, 0, 0, 0, "R5 word swap neg");
        drive(9, 64'h00FF_0001_0000_8000, 0, 0, 0, 0, "R6 zero test");
        drive(9, 64'h0, 0, 0, 0, 0, "R6 all zero");
        drive(10, 64'h8000_0000_0000_0000, 0, 63, 0, 0, "R7 bit 63");
        drive(10, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0, 0, "R7 bit 0 clear");
        drive(10, 64'h0000_0000_0010_0000, 0, 20, 0, 0, "R7 bit 20");
        drive(11, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, "R8 rotate zero");
        drive(11, 64'h0123_4567_89AB_CDEF, 0, 4, 0, 0, "R8 rotate 4");
        drive(11, 64'h8000_0000_0000_0001, 0, 63, 0, 0, "R8 rotate 63");
        drive(12, 64'hFFFF_0000_0000_0001, 0, 1, 0, 0, "R8 word rotate neg");
        drive(12, 64'h0000_0000_1234_5678, 0, 40, 0, 0, "R8 word amount bit5");
        drive(13, 64'hFFFF, 64'h1, 3, 3, 1, "R9 undefined 13");
        drive(15, 64'h1234, 64'h1, 3, 3, 1, "R9 undefined 15");
        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule